// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Write Mode

This block is a true dual-port synchronous RAM. Ports A and B each have their own clock, enable, write enable, address, data and parity inputs, and data and parity outputs. Both ports use the same word width, which can be 1, 2, 4, 9, 18 or 36 bits. The depth follows from a fixed total capacity divided by that width. With the default capacity of 36864 bits, the RAM holds 1024 words of 36 bits. At widths of 9, 18 and 36, the top one, two or four bits of each word travel on the parity bus and the rest on the data bus. At narrower widths the parity output is tied to zero.

Each port chooses three things on its own:
- how its output behaves when it writes: it shows the new word, shows the old word, or holds;
- whether an extra output register follows the read stage, adding one cycle of latency;
- the value a synchronous set/reset input loads into the last output stage.

Set/reset acts only on the output path. A write in the same cycle still reaches the memory. When both ports write the same word on different edges, the later write is the one a read returns.

Top module: `twin_port_ram`

## Requirements
- R1: In write-first mode, an enabled write (enable=1, write enable=1) puts the word being written on the read stage at the same edge.
- R2: In read-first mode, an enabled write puts the word held at that address before the write on the read stage. The memory still takes the new word.
- R3: In no-change mode, an enabled write leaves the read stage unchanged.
- R4: An enabled read (write enable=0) shows the addressed word on the outputs one edge after the address is sampled when the port has no output register, and two edges after when it has one.
- R5: When the output register is present, it loads only on edges where the port's register clock enable is 1. Otherwise the outputs hold.
- R6: Set/reset loads the port's reset value into its last output stage. Without the output register, this happens when enable=1. With the register, it happens when the register clock enable=1. Memory contents are never changed by set/reset, and a write given in the same cycle still lands.
- R7: Set/reset takes priority over a read or a write-mode update of the output stage on the same edge.
- R8: With enable=0, a port neither writes memory nor changes its read stage, whatever its write enable, address and data inputs are.
- R9: At widths of 9, 18 and 36, word bits above the data width map to the parity bus. At 36 bits, word bits 35..32 (including those of the reset value) appear on parity outputs 3..0, and bits 31..0 appear on the data outputs.
- R10: At widths of 1, 2 and 4, the parity output is always zero.
- R11: A word written through one port is returned by a later read through the other port. Of two writes to one address on different edges, the later one is stored.
- R12: The depth is the total capacity divided by the width. The lowest and highest addresses are distinct, usable words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous output set/reset |
| regce_a | input | 1 | Port A output register clock enable |
| addr_a | input | log2(depth) | Port A word address |
| din_a | input | data width | Port A write data |
| pin_a | input | max(parity width,1) | Port A write parity bits |
| dout_a | output | data width | Port A read data |
| pout_a | output | max(parity width,1) | Port A read parity bits |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous output set/reset |
| regce_b | input | 1 | Port B output register clock enable |
| addr_b | input | log2(depth) | Port B word address |
| din_b | input | data width | Port B write data |
| pin_b | input | max(parity width,1) | Port B write parity bits |
| dout_b | output | data width | Port B read data |
| pout_b | output | max(parity width,1) | Port B read parity bits |

## Verification
The hardest case to reach is the read-first collision on a pipelined port. The old word appears only after a second edge, and only if the register clock enable lines up with it. The stimulus therefore primes the register with a known word, writes a different word through that port, and then clocks the register alone so the old contents reach the pins. A second hard case is a set/reset that coincides with a write. The bench gives both in one cycle, checks that the output shows the reset value, then reads the address back to prove the write reached memory.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  // parity bits carried by one word
  function automatic int par_w(input int w);
    return (w >= 9) ? (w / 9) : 0;
  endfunction

  // data bits carried by one word
  function automatic int dat_w(input int w);
    return w - par_w(w);
  endfunction

  // parity bus is never narrower than one bit
  function automatic int pbus_w(input int w);
    return (par_w(w) > 0) ? par_w(w) : 1;
  endfunction

  function automatic int depth_of(input int total, input int w);
    return total / w;
  endfunction

  function automatic int aw_of(input int total, input int w);
    return (depth_of(total, w) > 1) ? $clog2(depth_of(total, w)) : 1;
  endfunction

endpackage

// File: rtl/word_store.sv
// Two banks, one per writing port, plus one flag bit per word and per port.
// The flags record which bank holds the most recent write to each word.
module word_store #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk_a,
  input  logic          wen_a,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  wdata_a,
  output logic [W-1:0]  rdata_a,
  input  logic          clk_b,
  input  logic          wen_b,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  wdata_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] bank_a [DEPTH];
  logic [W-1:0] bank_b [DEPTH];
  logic         flag_a [DEPTH];
  logic         flag_b [DEPTH];

  // A write from A makes the flags equal, so bank A is newest.
  always_ff @(posedge clk_a) begin
    if (wen_a) begin
      bank_a[addr_a] <= wdata_a;
      flag_a[addr_a] <= flag_b[addr_a];
    end
  end

  // A write from B makes the flags differ, so bank B is newest.
  always_ff @(posedge clk_b) begin
    if (wen_b) begin
      bank_b[addr_b] <= wdata_b;
      flag_b[addr_b] <= ~flag_a[addr_b];
    end
  end

  logic b_newest_a, b_newest_b;
  assign b_newest_a = flag_a[addr_a] ^ flag_b[addr_a];
  assign b_newest_b = flag_a[addr_b] ^ flag_b[addr_b];
  assign rdata_a    = b_newest_a ? bank_b[addr_a] : bank_a[addr_a];
  assign rdata_b    = b_newest_b ? bank_b[addr_b] : bank_a[addr_b];

endmodule

// File: rtl/field_join.sv
// Packs the parity and data buses into one stored word.
module field_join import tdp_pkg::*; #(
  parameter int W = 36
) (
  input  logic [dat_w(W)-1:0]  din,
  input  logic [pbus_w(W)-1:0] pin,
  output logic [W-1:0]         word
);
  localparam int PB = par_w(W);

  generate
    if (PB > 0) begin : g_par
      assign word = {pin, din};
    end else begin : g_nopar
      assign word = din;
      logic unused_pin;
      assign unused_pin = ^pin;
    end
  endgenerate
endmodule

// File: rtl/field_split.sv
// Unpacks one output word into the data and parity buses.
module field_split import tdp_pkg::*; #(
  parameter int W = 36
) (
  input  logic [W-1:0]         word,
  output logic [dat_w(W)-1:0]  dout,
  output logic [pbus_w(W)-1:0] pout
);
  localparam int PB = par_w(W);
  localparam int DW = dat_w(W);

  assign dout = word[DW-1:0];

  generate
    if (PB > 0) begin : g_par
      assign pout = word[W-1:DW];
    end else begin : g_nopar
      assign pout = '0;
    end
  endgenerate
endmodule

// File: rtl/port_stage.sv
// Read stage (updated under the port enable) followed by an optional register.
module port_stage import tdp_pkg::*; #(
  parameter int             W      = 36,
  parameter wmode_e         MODE   = WM_WRITE_FIRST,
  parameter int             PIPE   = 0,
  parameter logic [W-1:0]   RSTVAL = '0
) (
  input  logic         clk,
  input  logic         en,
  input  logic         we,
  input  logic         rst,
  input  logic         regce,
  input  logic [W-1:0] wword,
  input  logic [W-1:0] rword,
  output logic [W-1:0] lat,
  output logic [W-1:0] q
);

  // Reset lands in the read stage only when it is the last stage.
  logic lat_rst;
  assign lat_rst = rst && (PIPE == 0);

  always_ff @(posedge clk) begin
    if (en) begin
      if (lat_rst) begin
        lat <= RSTVAL;
      end else if (we) begin
        if (MODE == WM_WRITE_FIRST) begin
          lat <= wword;
        end else if (MODE == WM_READ_FIRST) begin
          lat <= rword;
        end
      end else begin
        lat <= rword;
      end
    end
  end

  generate
    if (PIPE != 0) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (regce) begin
          q_r <= rst ? RSTVAL : lat;
        end
      end
      assign q = q_r;
    end else begin : g_bypass
      assign q = lat;
      logic unused_regce;
      assign unused_regce = regce;
    end
  endgenerate

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram import tdp_pkg::*; #(
  parameter int                  TOTAL_BITS = 36864,
  parameter int                  PORT_W     = 36,
  parameter wmode_e              A_MODE     = WM_WRITE_FIRST,
  parameter wmode_e              B_MODE     = WM_WRITE_FIRST,
  parameter int                  A_PIPE     = 0,
  parameter int                  B_PIPE     = 0,
  parameter logic [PORT_W-1:0]   A_RSTVAL   = '0,
  parameter logic [PORT_W-1:0]   B_RSTVAL   = '0
) (
  input  logic                                   clk_a,
  input  logic                                   en_a,
  input  logic                                   we_a,
  input  logic                                   rst_a,
  input  logic                                   regce_a,
  input  logic [aw_of(TOTAL_BITS, PORT_W)-1:0]   addr_a,
  input  logic [dat_w(PORT_W)-1:0]               din_a,
  input  logic [pbus_w(PORT_W)-1:0]              pin_a,
  output logic [dat_w(PORT_W)-1:0]               dout_a,
  output logic [pbus_w(PORT_W)-1:0]              pout_a,
  input  logic                                   clk_b,
  input  logic                                   en_b,
  input  logic                                   we_b,
  input  logic                                   rst_b,
  input  logic                                   regce_b,
  input  logic [aw_of(TOTAL_BITS, PORT_W)-1:0]   addr_b,
  input  logic [dat_w(PORT_W)-1:0]               din_b,
  input  logic [pbus_w(PORT_W)-1:0]              pin_b,
  output logic [dat_w(PORT_W)-1:0]               dout_b,
  output logic [pbus_w(PORT_W)-1:0]              pout_b
);

  localparam int DEPTH = depth_of(TOTAL_BITS, PORT_W);
  localparam int AW    = aw_of(TOTAL_BITS, PORT_W);

  // named internal events and words, visible to the bound checker
  logic              wen_a, wen_b;
  logic [PORT_W-1:0] wword_a, wword_b;
  logic [PORT_W-1:0] rword_a, rword_b;
  logic [PORT_W-1:0] lat_a, lat_b;
  logic [PORT_W-1:0] q_a, q_b;

  assign wen_a = en_a && we_a;
  assign wen_b = en_b && we_b;

  field_join #(.W(PORT_W)) join_a_i (.din(din_a), .pin(pin_a), .word(wword_a));
  field_join #(.W(PORT_W)) join_b_i (.din(din_b), .pin(pin_b), .word(wword_b));

  word_store #(.W(PORT_W), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk_a(clk_a), .wen_a(wen_a), .addr_a(addr_a), .wdata_a(wword_a), .rdata_a(rword_a),
    .clk_b(clk_b), .wen_b(wen_b), .addr_b(addr_b), .wdata_b(wword_b), .rdata_b(rword_b)
  );

  port_stage #(.W(PORT_W), .MODE(A_MODE), .PIPE(A_PIPE), .RSTVAL(A_RSTVAL)) stage_a_i (
    .clk(clk_a), .en(en_a), .we(we_a), .rst(rst_a), .regce(regce_a),
    .wword(wword_a), .rword(rword_a), .lat(lat_a), .q(q_a)
  );

  port_stage #(.W(PORT_W), .MODE(B_MODE), .PIPE(B_PIPE), .RSTVAL(B_RSTVAL)) stage_b_i (
    .clk(clk_b), .en(en_b), .we(we_b), .rst(rst_b), .regce(regce_b),
    .wword(wword_b), .rword(rword_b), .lat(lat_b), .q(q_b)
  );

  field_split #(.W(PORT_W)) split_a_i (.word(q_a), .dout(dout_a), .pout(pout_a));
  field_split #(.W(PORT_W)) split_b_i (.word(q_b), .dout(dout_b), .pout(pout_b));

endmodule

// File: rtl/port_chk.sv
module port_chk import tdp_pkg::*; #(
  parameter int           W      = 36,
  parameter wmode_e       MODE   = WM_WRITE_FIRST,
  parameter int           PIPE   = 0,
  parameter logic [W-1:0] RSTVAL = '0
) (
  input logic         clk,
  input logic         en,
  input logic         we,
  input logic         rst,
  input logic         regce,
  input logic [W-1:0] wword,
  input logic [W-1:0] rword,
  input logic [W-1:0] lat,
  input logic [W-1:0] q
);

  logic warm;
  always_ff @(posedge clk) warm <= 1'b1;

  logic upd;
  assign upd = en && we && !(rst && PIPE == 0);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (warm !== 1'b1)
    !en |=> $stable(lat));

  generate
    if (MODE == WM_WRITE_FIRST) begin : g_wf
      assert_new_word_R1: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        upd |=> lat == $past(wword));
    end
    if (MODE == WM_READ_FIRST) begin : g_rf
      assert_old_word_R2: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        upd |=> lat == $past(rword));
    end
    if (MODE == WM_NO_CHANGE) begin : g_nc
      assert_hold_word_R3: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        upd |=> $stable(lat));
    end
    if (PIPE != 0) begin : g_pipe
      assert_regce_gate_R5: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        !regce |=> $stable(q));
      assert_reset_reg_R6: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        (regce && rst) |=> q == RSTVAL);
      assert_reg_follows_R4: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        (regce && !rst) |=> q == $past(lat));
    end else begin : g_nopipe
      assert_reset_lat_R6: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        (en && rst) |=> q == RSTVAL);
      assert_read_lat_R4: assert property (@(posedge clk) disable iff (warm !== 1'b1)
        (en && !we && !rst) |=> q == $past(rword));
    end
  endgenerate

endmodule

bind twin_port_ram port_chk #(.W(PORT_W), .MODE(A_MODE), .PIPE(A_PIPE), .RSTVAL(A_RSTVAL)) chk_a_i (
  .clk(clk_a), .en(en_a), .we(we_a), .rst(rst_a), .regce(regce_a),
  .wword(wword_a), .rword(rword_a), .lat(lat_a), .q(q_a)
);

bind twin_port_ram port_chk #(.W(PORT_W), .MODE(B_MODE), .PIPE(B_PIPE), .RSTVAL(B_RSTVAL)) chk_b_i (
  .clk(clk_b), .en(en_b), .we(we_b), .rst(rst_b), .regce(regce_b),
  .wword(wword_b), .rword(rword_b), .lat(lat_b), .q(q_b)
);

// File: tb/twin_port_ram_tb_top.sv
module twin_port_ram_tb_top;
  import tdp_pkg::*;

  localparam int          CLK_P = 10;
  localparam logic [35:0] RST_A = 36'h9_1234_5678;
  localparam logic [35:0] RST_B = 36'h6_DEAD_BEEF;
  localparam logic [3:0]  RST_NA = 4'hA;
  localparam logic [3:0]  RST_NB = 4'h5;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // 36-bit instance: A write-first unregistered, B read-first registered
  logic        a_en, a_we, a_rst, a_ce, b_en, b_we, b_rst, b_ce;
  logic [9:0]  a_addr, b_addr;
  logic [31:0] a_din, b_din, a_dout, b_dout;
  logic [3:0]  a_pin, b_pin, a_pout, b_pout;

  twin_port_ram #(.TOTAL_BITS(36864), .PORT_W(36),
    .A_MODE(WM_WRITE_FIRST), .B_MODE(WM_READ_FIRST),
    .A_PIPE(0), .B_PIPE(1), .A_RSTVAL(RST_A), .B_RSTVAL(RST_B)) dut_i (
    .clk_a(clk), .en_a(a_en), .we_a(a_we), .rst_a(a_rst), .regce_a(a_ce),
    .addr_a(a_addr), .din_a(a_din), .pin_a(a_pin), .dout_a(a_dout), .pout_a(a_pout),
    .clk_b(clk), .en_b(b_en), .we_b(b_we), .rst_b(b_rst), .regce_b(b_ce),
    .addr_b(b_addr), .din_b(b_din), .pin_b(b_pin), .dout_b(b_dout), .pout_b(b_pout)
  );

  // 4-bit instance: A no-change unregistered, B write-first registered
  logic       na_en, na_we, na_rst, na_ce, nb_en, nb_we, nb_rst, nb_ce;
  logic [9:0] na_addr, nb_addr;
  logic [3:0] na_din, nb_din, na_dout, nb_dout;
  logic [0:0] na_pin, nb_pin, na_pout, nb_pout;

  twin_port_ram #(.TOTAL_BITS(4096), .PORT_W(4),
    .A_MODE(WM_NO_CHANGE), .B_MODE(WM_WRITE_FIRST),
    .A_PIPE(0), .B_PIPE(1), .A_RSTVAL(RST_NA), .B_RSTVAL(RST_NB)) dut_n_i (
    .clk_a(clk), .en_a(na_en), .we_a(na_we), .rst_a(na_rst), .regce_a(na_ce),
    .addr_a(na_addr), .din_a(na_din), .pin_a(na_pin), .dout_a(na_dout), .pout_a(na_pout),
    .clk_b(clk), .en_b(nb_en), .we_b(nb_we), .rst_b(nb_rst), .regce_b(nb_ce),
    .addr_b(nb_addr), .din_b(nb_din), .pin_b(nb_pin), .dout_b(nb_dout), .pout_b(nb_pout)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic port_a(input logic en, we, rst, input logic [9:0] addr, input logic [35:0] w);
    a_en = en; a_we = we; a_rst = rst; a_addr = addr; a_din = w[31:0]; a_pin = w[35:32];
  endtask

  task automatic port_b(input logic en, we, rst, ce, input logic [9:0] addr, input logic [35:0] w);
    b_en = en; b_we = we; b_rst = rst; b_ce = ce; b_addr = addr; b_din = w[31:0]; b_pin = w[35:32];
  endtask

  function automatic logic [35:0] out_a();
    return {a_pout, a_dout};
  endfunction

  function automatic logic [35:0] out_b();
    return {b_pout, b_dout};
  endfunction

  localparam logic [35:0] W0 = 36'h1_0F0F_0001;
  localparam logic [35:0] W1 = 36'hE_7070_0002;
  localparam logic [35:0] W2 = 36'h3_CAFE_0003;
  localparam logic [35:0] W3 = 36'hC_5555_0004;
  localparam logic [35:0] W4 = 36'h5_AAAA_0005;
  localparam logic [35:0] W5 = 36'hA_0000_0006;
  localparam logic [35:0] W9 = 36'hF_FFFF_FFFF;

  task automatic t_reset();
    port_a(1, 0, 1, 0, '0);
    port_b(1, 0, 1, 1, 0, '0);
    na_en = 1; na_rst = 1; nb_en = 1; nb_rst = 1; nb_ce = 1;
    tick();
    chk("R6 R9 port A reset word", out_a(), RST_A);
    chk("R9 port A parity from bits 35..32", {32'd0, a_pout}, {32'd0, RST_A[35:32]});
    chk("R6 port B register reset", out_b(), RST_B);
    chk("R6 narrow A reset", {32'd0, na_dout}, {32'd0, RST_NA});
    chk("R6 narrow B reset", {32'd0, nb_dout}, {32'd0, RST_NB});
    chk("R10 narrow parity zero", {35'd0, na_pout}, 36'd0);
    port_a(0, 0, 0, 0, '0);
    port_b(0, 0, 0, 0, 0, '0);
    na_rst = 0; na_en = 0; nb_rst = 0; nb_en = 0; nb_ce = 0;
  endtask

  task automatic t_write_first();
    port_a(1, 1, 0, 7, W0); tick();
    chk("R1 write-first shows W0", out_a(), W0);
    port_a(1, 1, 0, 5, W1); tick();
    chk("R1 R9 write-first shows W1", out_a(), W1);
    port_a(0, 0, 0, 5, '0);
  endtask

  task automatic t_latency();
    port_a(1, 0, 0, 7, '0); tick();
    chk("R4 one-cycle read on A", out_a(), W0);
    port_b(1, 0, 0, 1, 7, '0); tick();
    port_b(1, 0, 0, 1, 5, '0); tick();
    chk("R4 R11 registered B shows earlier address", out_b(), W0);
    tick();
    chk("R4 R11 registered B after two edges", out_b(), W1);
    port_a(0, 0, 0, 0, '0);
  endtask

  task automatic t_read_first();
    port_b(1, 1, 0, 1, 7, W2); tick();
    port_b(0, 0, 0, 1, 7, '0); tick();
    chk("R2 read-first returns old word", out_b(), W0);
    port_b(1, 0, 0, 1, 7, '0); tick(); tick();
    chk("R2 read-first memory took new word", out_b(), W2);
    port_a(1, 0, 0, 7, '0); tick();
    chk("R11 A sees word B wrote", out_a(), W2);
    port_a(0, 0, 0, 0, '0);
  endtask

  task automatic t_regce();
    port_b(1, 0, 0, 0, 5, '0); tick(); tick();
    chk("R5 register holds with clock enable low", out_b(), W2);
    port_b(0, 0, 0, 1, 5, '0); tick();
    chk("R5 register loads with clock enable high", out_b(), W1);
    port_b(0, 0, 0, 0, 0, '0);
  endtask

  task automatic t_disabled();
    port_a(0, 1, 0, 5, W9); tick();
    chk("R8 disabled port output held", out_a(), W2);
    port_a(0, 1, 1, 5, W9); tick();
    chk("R8 disabled port ignores reset", out_a(), W2);
    port_a(1, 0, 0, 5, '0); tick();
    chk("R8 disabled write not stored", out_a(), W1);
  endtask

  task automatic t_rst_priority();
    port_a(1, 1, 1, 9, W3); tick();
    chk("R7 reset beats write-first update", out_a(), RST_A);
    port_a(1, 0, 1, 5, '0); tick();
    chk("R7 reset beats read", out_a(), RST_A);
    port_a(1, 0, 0, 9, '0); tick();
    chk("R6 write under reset landed", out_a(), W3);
    port_a(1, 0, 0, 5, '0); tick();
    chk("R6 reset left memory intact", out_a(), W1);
    port_a(0, 0, 0, 0, '0);
  endtask

  task automatic t_narrow();
    na_en = 1; na_we = 1; na_addr = 3; na_din = 4'h6; na_pin = 1'b1; tick();
    chk("R3 no-change holds output", {32'd0, na_dout}, {32'd0, RST_NA});
    na_we = 0; tick();
    chk("R3 no-change write stored", {32'd0, na_dout}, 36'h6);
    chk("R10 parity input ignored", {35'd0, na_pout}, 36'd0);
    na_en = 0;
    nb_en = 1; nb_we = 1; nb_ce = 1; nb_addr = 4; nb_din = 4'h9; nb_pin = 1'b1; tick();
    nb_en = 0; nb_we = 0; tick();
    chk("R1 registered write-first", {32'd0, nb_dout}, 36'h9);
    chk("R10 narrow B parity zero", {35'd0, nb_pout}, 36'd0);
    nb_ce = 0;
  endtask

  task automatic t_depth();
    chk("R12 address width", 36'($bits(a_addr)), 36'd10);
    port_a(1, 1, 0, 10'd1023, W4); tick();
    port_a(1, 1, 0, 10'd0, W5); tick();
    port_a(1, 0, 0, 10'd1023, '0); tick();
    chk("R12 top address", out_a(), W4);
    port_a(1, 0, 0, 10'd0, '0); tick();
    chk("R12 bottom address", out_a(), W5);
    port_a(0, 0, 0, 0, '0);
  endtask

  task automatic t_last_writer();
    port_a(1, 1, 0, 20, W0); tick();
    port_a(0, 0, 0, 0, '0);
    port_b(1, 1, 0, 0, 20, W3); tick();
    port_b(0, 0, 0, 0, 0, '0);
    port_a(1, 0, 0, 20, '0); tick();
    chk("R11 later B write wins", out_a(), W3);
    port_a(1, 1, 0, 20, W4); tick();
    port_a(0, 0, 0, 0, '0);
    port_b(1, 0, 0, 1, 20, '0); tick(); tick();
    chk("R11 later A write wins", out_b(), W4);
    port_b(0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    port_a(0, 0, 0, 0, '0); a_ce = 0;
    port_b(0, 0, 0, 0, 0, '0);
    na_en = 0; na_we = 0; na_rst = 0; na_ce = 0; na_addr = 0; na_din = 0; na_pin = 0;
    nb_en = 0; nb_we = 0; nb_rst = 0; nb_ce = 0; nb_addr = 0; nb_din = 0; nb_pin = 0;
    @(negedge clk);
    t_reset();
    t_write_first();
    t_latency();
    t_read_first();
    t_regce();
    t_disabled();
    t_rst_priority();
    t_narrow();
    t_depth();
    t_last_writer();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule